// File: doc/BRIEF.md
# DRAM Supply-Voltage Change Sequencer

This block sits between the command scheduler of an SDRAM controller and the memory command bus. It moves the memory safely from one supply range (low, 1.35 V) to the other (standard, 1.5 V), in either direction. A one-cycle change request carries the target range. The sequencer then quiets the command bus. It closes any open rows with a precharge-all and asks the external supply to switch. It waits for the supply to report that the new level is stable. Once it is, it resets the DLL through a mode-register write, waits a programmable relock time, and starts a ZQ initial calibration that runs for a programmable time.

Outside a sequence, scheduler commands pass through unchanged. During the supply transition only NOP (code 0) reaches the bus. Once the supply is stable, the scheduler may issue commands again, except reads. Reads stay held back until relock and calibration have both finished. If the supply never reports stable within a programmable number of cycles, the sequencer stops in an error state. It raises a fault flag and holds the bus at NOP until reset.

Top module: `vchg_seq`

## Requirements
- R1: `busy` is low only in the idle state, where `mem_cmd` equals `host_cmd` and `host_pass` is high. A `chg_req` seen in idle at a clock edge makes `busy` high from the next cycle. After reset `busy`, `fault`, `supply_req` and `supply_target` are low.
- R2: For the first `DRAIN_CYC` cycles after a request is captured, `mem_cmd` is NOP (code 0), whatever `host_cmd` is.
- R3: If `banks_open` is high in the last drain cycle, the next cycle issues a precharge-all (code 4), followed by `TRP_CYC-1` NOP cycles. If it is low, no precharge-all is issued and the supply request follows the drain directly.
- R4: `supply_req` rises in the cycle after the drain or precharge phase. It stays high, with `mem_cmd` at NOP, up to and including the cycle in which `supply_stable` is sampled high.
- R5: In the cycle after `supply_stable` is sampled high, `supply_req` is low and `mem_cmd` carries the mode-register write that resets the DLL (code 5).
- R6: From the DLL reset until the done cycle, a read from the host (code 2) becomes NOP. Every other host command passes through, except in the cycles in which the sequencer issues its own command. In the done cycle reads pass again.
- R7: After `dll_lock_cycles` cycles of relock wait, a ZQ initial calibration (code 6) is issued. It is followed by `zq_cycles` further cycles, then one done cycle with `busy` high, then idle.
- R8: If `supply_stable` is not sampled high within `stable_limit` cycles of waiting, `fault` and `busy` go high, `supply_req` goes low, and `mem_cmd` stays NOP until reset.
- R9: A `chg_req` while `busy` is high has no effect on timing, commands or target.
- R10: `supply_target` takes the value of `chg_target` when a request is captured and holds it for the whole sequence. Both directions follow the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_req | input | 1 | Supply change request, sampled in idle |
| chg_target | input | 1 | Target range: 0 low (1.35 V), 1 standard (1.5 V) |
| banks_open | input | 1 | Any bank holds an open row |
| supply_stable | input | 1 | External supply reports the new level settled |
| host_cmd | input | 3 | Command from the scheduler |
| dll_lock_cycles | input | CW | Relock wait length in cycles (at least 1) |
| zq_cycles | input | CW | Calibration time after the ZQ command in cycles (at least 1) |
| stable_limit | input | CW | Maximum wait for supply stability in cycles (at least 1) |
| mem_cmd | output | 3 | Command driven to the memory |
| host_pass | output | 1 | `host_cmd` is the command on the bus this cycle |
| supply_req | output | 1 | Request to the supply to move to `supply_target` |
| supply_target | output | 1 | Latched target range |
| busy | output | 1 | A change sequence is in progress or has faulted |
| fault | output | 1 | Supply did not settle in time |

## Verification
The hardest cases to reach are the edges of the stability wait. Stability may come in the very last allowed cycle, which must still succeed. Or it may never come, which must end in the error state exactly one cycle later. The bench reaches both by choosing, for each sequence, a stability delay that is either random within the limit, equal to the limit, or absent. It pairs this with random open-bank status, random timer lengths, random scheduler commands and stray change requests. Each cycle's expected command and flags are computed from the phase boundaries that follow from these choices.

// File: rtl/vchg_pkg.sv
package vchg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_PRECHARGE,
        ST_SWITCH,
        ST_WAIT_STABLE,
        ST_DLL_RESET,
        ST_DLL_LOCK_WAIT,
        ST_ZQ_INIT,
        ST_DONE,
        ST_ERROR
    } vchg_state_e;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PREA = 3'd4,
        CMD_MRS  = 3'd5,
        CMD_ZQCL = 3'd6,
        CMD_REF  = 3'd7
    } dram_cmd_e;

    function automatic logic is_read(input logic [2:0] c);
        return c == 3'(CMD_RD);
    endfunction

    // states in which the supply is moving and the bus must stay quiet
    function automatic logic supply_phase(input vchg_state_e s);
        return (s == ST_SWITCH) || (s == ST_WAIT_STABLE);
    endfunction

endpackage

// File: rtl/vchg_timer.sv
module vchg_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/vchg_gate.sv
module vchg_gate
    import vchg_pkg::*;
(
    input  vchg_state_e st,
    input  logic        first,
    input  logic [2:0]  host_cmd,
    output logic [2:0]  mem_cmd,
    output logic        host_pass
);
    always_comb begin
        mem_cmd   = 3'(CMD_NOP);
        host_pass = 1'b0;
        unique case (st)
            ST_IDLE, ST_DONE: begin
                mem_cmd   = host_cmd;
                host_pass = 1'b1;
            end
            ST_PRECHARGE: begin
                if (first) mem_cmd = 3'(CMD_PREA);
            end
            ST_DLL_RESET: begin
                mem_cmd = 3'(CMD_MRS);
            end
            ST_DLL_LOCK_WAIT: begin
                if (!is_read(host_cmd)) begin
                    mem_cmd   = host_cmd;
                    host_pass = 1'b1;
                end
            end
            ST_ZQ_INIT: begin
                if (first) begin
                    mem_cmd = 3'(CMD_ZQCL);
                end else if (!is_read(host_cmd)) begin
                    mem_cmd   = host_cmd;
                    host_pass = 1'b1;
                end
            end
            default: begin
                mem_cmd = 3'(CMD_NOP);
            end
        endcase
    end
endmodule

// File: rtl/vchg_seq.sv
module vchg_seq
    import vchg_pkg::*;
#(
    parameter int CW        = 16,
    parameter int DRAIN_CYC = 2,
    parameter int TRP_CYC   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chg_req,
    input  logic          chg_target,
    input  logic          banks_open,
    input  logic          supply_stable,
    input  logic [2:0]    host_cmd,
    input  logic [CW-1:0] dll_lock_cycles,
    input  logic [CW-1:0] zq_cycles,
    input  logic [CW-1:0] stable_limit,
    output logic [2:0]    mem_cmd,
    output logic          host_pass,
    output logic          supply_req,
    output logic          supply_target,
    output logic          busy,
    output logic          fault
);
    localparam logic [CW-1:0] DRAIN_LD = CW'(DRAIN_CYC - 1);
    localparam logic [CW-1:0] TRP_LD   = CW'(TRP_CYC - 1);

    vchg_state_e   st, nxt;
    logic          first;
    logic          tgt_q;
    logic          expired;
    logic          t_load;
    logic [CW-1:0] t_val;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:          if (chg_req) nxt = ST_DRAIN;
            ST_DRAIN:         if (expired) nxt = banks_open ? ST_PRECHARGE : ST_SWITCH;
            ST_PRECHARGE:     if (expired) nxt = ST_SWITCH;
            ST_SWITCH:        nxt = ST_WAIT_STABLE;
            ST_WAIT_STABLE: begin
                if (supply_stable)  nxt = ST_DLL_RESET;
                else if (expired)   nxt = ST_ERROR;
            end
            ST_DLL_RESET:     nxt = ST_DLL_LOCK_WAIT;
            ST_DLL_LOCK_WAIT: if (expired) nxt = ST_ZQ_INIT;
            ST_ZQ_INIT:       if (expired) nxt = ST_DONE;
            ST_DONE:          nxt = ST_IDLE;
            ST_ERROR:         nxt = ST_ERROR;
            default:          nxt = ST_IDLE;
        endcase
    end

    // timer is loaded on every state change with the length of the new state
    always_comb begin
        t_load = (nxt != st);
        unique case (nxt)
            ST_DRAIN:         t_val = DRAIN_LD;
            ST_PRECHARGE:     t_val = TRP_LD;
            ST_WAIT_STABLE:   t_val = stable_limit - 1'b1;
            ST_DLL_LOCK_WAIT: t_val = dll_lock_cycles - 1'b1;
            ST_ZQ_INIT:       t_val = zq_cycles;
            default:          t_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            first <= 1'b0;
            tgt_q <= 1'b0;
        end else begin
            st    <= nxt;
            first <= (nxt != st);
            if (st == ST_IDLE && chg_req)
                tgt_q <= chg_target;
        end
    end

    vchg_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (expired)
    );

    vchg_gate u_gate (
        .st        (st),
        .first     (first),
        .host_cmd  (host_cmd),
        .mem_cmd   (mem_cmd),
        .host_pass (host_pass)
    );

    assign supply_req    = supply_phase(st);
    assign supply_target = tgt_q;
    assign busy          = (st != ST_IDLE);
    assign fault         = (st == ST_ERROR);
endmodule

// File: rtl/vchg_seq_chk.sv
module vchg_seq_chk
    import vchg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        chg_req,
    input logic        supply_stable,
    input logic [2:0]  host_cmd,
    input logic [2:0]  mem_cmd,
    input logic        supply_req,
    input logic        supply_target,
    input logic        busy,
    input logic        fault,
    input vchg_state_e st
);
    p_idle_pass_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> mem_cmd == host_cmd);

    p_busy_on_req_r1: assert property (@(posedge clk) disable iff (rst)
        (chg_req && !busy) |=> busy);

    p_quiet_supply_r4: assert property (@(posedge clk) disable iff (rst)
        supply_req |-> mem_cmd == 3'(CMD_NOP));

    p_dll_after_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DLL_RESET) |-> ($past(supply_stable) && $past(supply_req)));

    p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && st != ST_DONE) |-> mem_cmd != 3'(CMD_RD));

    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        fault |-> (busy && !supply_req && mem_cmd == 3'(CMD_NOP)));

    p_target_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (supply_req && $past(supply_req)) |-> $stable(supply_target));
endmodule

bind vchg_seq vchg_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .chg_req       (chg_req),
    .supply_stable (supply_stable),
    .host_cmd      (host_cmd),
    .mem_cmd       (mem_cmd),
    .supply_req    (supply_req),
    .supply_target (supply_target),
    .busy          (busy),
    .fault         (fault),
    .st            (st)
);

// File: tb/vchg_seq_tb.sv
module vchg_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;
    localparam int DRAIN_CYC  = 2;
    localparam int TRP_CYC    = 4;
    localparam int NEVER      = 1 << 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chg_req = 1'b0;
    logic          chg_target = 1'b0;
    logic          banks_open = 1'b0;
    logic          supply_stable = 1'b0;
    logic [2:0]    host_cmd = 3'd0;
    logic [CW-1:0] dll_lock_cycles = 16'd1;
    logic [CW-1:0] zq_cycles = 16'd1;
    logic [CW-1:0] stable_limit = 16'd4;
    logic [2:0]    mem_cmd;
    logic          host_pass;
    logic          supply_req;
    logic          supply_target;
    logic          busy;
    logic          fault;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vchg_seq #(.CW(CW), .DRAIN_CYC(DRAIN_CYC), .TRP_CYC(TRP_CYC)) u_dut (
        .clk(clk), .rst(rst), .chg_req(chg_req), .chg_target(chg_target),
        .banks_open(banks_open), .supply_stable(supply_stable), .host_cmd(host_cmd),
        .dll_lock_cycles(dll_lock_cycles), .zq_cycles(zq_cycles),
        .stable_limit(stable_limit), .mem_cmd(mem_cmd), .host_pass(host_pass),
        .supply_req(supply_req), .supply_target(supply_target), .busy(busy),
        .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // expected bus command and flags for cycle c of a sequence (c=1 is the first drain cycle)
    function automatic void expect_at(input int c, input int host, input int p, input int s,
                                      input int d, input int l, input int z,
                                      output int cmd, output bit sreq, output bit bsy,
                                      output string tag);
        sreq = (c >= s) && (c < d);
        bsy  = (c <= d + l + z + 2);
        if (c <= DRAIN_CYC) begin
            cmd = 0; tag = "R2";
        end else if (c <= DRAIN_CYC + p) begin
            cmd = (c == DRAIN_CYC + 1) ? 4 : 0; tag = "R3";
        end else if (c < d) begin
            cmd = 0; tag = "R4";
        end else if (c == d) begin
            cmd = 5; tag = "R5";
        end else if (c <= d + l) begin
            cmd = (host == 2) ? 0 : host; tag = "R6";
        end else if (c == d + l + 1) begin
            cmd = 6; tag = "R7";
        end else if (c <= d + l + z + 1) begin
            cmd = (host == 2) ? 0 : host; tag = "R6";
        end else begin
            cmd = host; tag = "R7";
        end
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; chg_req = 1'b0; supply_stable = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        host_cmd = 3'($urandom_range(0, 7));
        #1;
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(fault == 1'b0, "R1 reset fault", fault, 0);
        chk(supply_req == 1'b0, "R1 reset supply_req", supply_req, 0);
        chk(supply_target == 1'b0, "R1 reset target", supply_target, 0);
        chk(mem_cmd == host_cmd && host_pass, "R1 reset passthrough", mem_cmd, host_cmd);
    endtask

    task automatic start(input bit open, input bit tgt, input int l, input int z, input int lim);
        @(negedge clk);
        dll_lock_cycles = CW'(l);
        zq_cycles       = CW'(z);
        stable_limit    = CW'(lim);
        banks_open      = open;
        chg_target      = tgt;
        chg_req         = 1'b1;
        supply_stable   = 1'b0;
        host_cmd        = 3'($urandom_range(0, 7));
        #1;
        chk(!busy && mem_cmd == host_cmd, "R1 idle before request", mem_cmd, host_cmd);
    endtask

    // one cycle of the sequence: drive, then compare
    task automatic step(input int c, input bit tgt, input int p, input int s, input int d,
                        input int l, input int z, input bit stab, input bit stray);
        int  ecmd;
        bit  esreq, ebsy;
        string tag;
        @(negedge clk);
        host_cmd      = 3'($urandom_range(0, 7));
        chg_req       = stray && ($urandom_range(0, 5) == 0);
        chg_target    = 1'($urandom_range(0, 1));
        supply_stable = stab;
        #1;
        expect_at(c, int'(host_cmd), p, s, d, l, z, ecmd, esreq, ebsy, tag);
        chk(int'(mem_cmd) == ecmd, tag, mem_cmd, ecmd);
        chk(supply_req == esreq, "R4 supply_req", supply_req, esreq);
        chk(busy == ebsy, "R1 busy", busy, ebsy);
        chk(fault == 1'b0, "R8 no fault", fault, 0);
        if (esreq) chk(supply_target == tgt, "R10 target", supply_target, tgt);
    endtask

    task automatic run_seq(input bit open, input bit tgt, input int l, input int z,
                           input int lim, input int dly);
        int p = open ? TRP_CYC : 0;
        int s = DRAIN_CYC + p + 1;
        int d = s + dly + 1;
        start(open, tgt, l, z, lim);
        for (int c = 1; c <= d + l + z + 3; c++)
            step(c, tgt, p, s, d, l, z, (c >= s + dly) && (c < d + l + z + 3),
                 c <= d + l + z + 2);
        @(negedge clk);
        chg_req = 1'b0; supply_stable = 1'b0;
        #1;
        chk(!busy, "R9 stray requests started nothing", busy, 0);
        chk(supply_target == tgt, "R10 target kept after sequence", supply_target, tgt);
    endtask

    task automatic run_timeout(input bit open, input bit tgt, input int lim);
        int p = open ? TRP_CYC : 0;
        int s = DRAIN_CYC + p + 1;
        start(open, tgt, 3, 3, lim);
        for (int c = 1; c <= s + lim; c++)
            step(c, tgt, p, s, NEVER, 3, 3, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            host_cmd = 3'($urandom_range(0, 7));
            chg_req  = 1'($urandom_range(0, 1));
            supply_stable = (k > 3);
            #1;
            chk(fault == 1'b1, "R8 fault", fault, 1);
            chk(busy == 1'b1, "R8 busy", busy, 1);
            chk(supply_req == 1'b0, "R8 supply_req", supply_req, 0);
            chk(mem_cmd == 3'd0, "R8 nop", mem_cmd, 0);
        end
        do_reset();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // directed corners
        run_seq(1'b1, 1'b1, 1, 1, 4, 1);
        run_seq(1'b0, 1'b0, 1, 1, 4, 4);
        run_seq(1'b1, 1'b0, 5, 2, 1, 1);
        run_seq(1'b0, 1'b1, 2, 6, 6, 6);
        run_timeout(1'b1, 1'b1, 3);
        run_timeout(1'b0, 1'b0, 1);
        // random mix
        for (int i = 0; i < 30; i++) begin
            int lim = $urandom_range(1, 8);
            run_seq(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    $urandom_range(1, 6), $urandom_range(1, 6), lim,
                    $urandom_range(1, lim));
        end
        run_timeout(1'($urandom_range(0, 1)), 1'b1, $urandom_range(2, 8));
        run_seq(1'b1, 1'b0, 3, 3, 5, 5);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule